// File: doc/BRIEF.md
# Interrupt Pending, Mask and Service Register Unit

This unit keeps the per-source interrupt state of a 26-input interrupt controller. Each source request is edge-captured into a sticky pending bit. A per-source route bit steers a source either to the normal request line (IRQ) or to the fast request line (FIQ). A per-source mask bit blocks a source, and one global mask bit blocks every source at once. Three control bits enable the two request lines and select vectored IRQ handling. FIQ handling never uses vectored mode.

The set of pending, unmasked, IRQ-routed sources goes to an external priority arbiter. When the CPU acknowledges an IRQ, the arbiter's choice is loaded into an in-service register that never holds more than one bit. While that bit is set, no further IRQ is raised. Software ends service by writing ones to a service-clear register: one for IRQ sources and one for FIQ sources. The write drops the matching in-service and pending bits. All registers sit behind a small word-addressed bus with a combinational read port.

Top module: `intr_svc_unit`

## Requirements
- R1: After reset the control register reads 0x7, the mask register reads 0x07FFFFFF, pending, route and in-service read 0, and irq_req_o and fiq_req_o are low.
- R2: Source input bit i maps to bit i of every per-source register. A rising edge on it sets pending bit i at that clock edge, and the bit stays set after the input falls.
- R3: irq_cand_o bit i is high when pending bit i is 1, route bit i is 0, mask bit i is 0 and the global mask (mask register bit 26) is 0.
- R4: A route bit of 1 sends the source to FIQ. fiq_req_o is high when some pending source has route 1 and mask 0, the global mask is 0, and control bit 0 is 0.
- R5: irq_req_o is high when irq_cand_o is nonzero, control bit 1 is 0 and the in-service register is zero.
- R6: vec_mode_o is high exactly when control bit 2 is 0.
- R7: On irq_ack_i while in-service is zero, the lowest-numbered set bit of (arb_winner_i AND irq_cand_o) is loaded into in-service. An acknowledge while in-service is nonzero is ignored, and in-service never has more than one bit set.
- R8: Writing a word to the IRQ service-clear register (offset 5) clears the in-service bits at its 1 positions. It also clears the pending bits at those positions whose route bit is 0.
- R9: Writing a word to the FIQ service-clear register (offset 6) clears only the pending bits at its 1 positions whose route bit is 1.
- R10: A rising source edge in the same cycle as a clear of that bit leaves the pending bit set.
- R11: Register offsets are 0 control [2:0], 1 pending (read only), 2 route, 3 mask [26:0], 4 in-service (read only), 5 and 6 the write-only clears, which read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 26 | Raw source requests |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | Write when high with bus_sel_i |
| bus_addr_i | input | 3 | Register word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_cand_o | output | 26 | Pending unmasked IRQ sources for the arbiter |
| arb_winner_i | input | 26 | Arbiter choice, one-hot |
| irq_ack_i | input | 1 | CPU acknowledge of the IRQ |
| irq_req_o | output | 1 | IRQ request to the CPU |
| fiq_req_o | output | 1 | FIQ request to the CPU |
| vec_mode_o | output | 1 | Vectored IRQ handling selected |

## Verification
A table of source bursts is driven under different route and mask settings: all sources to IRQ, all sources to FIQ, the global mask, a split of IRQ and FIQ sources, and partial per-source masks. These cases separate the per-source mask from the global mask, and separate IRQ routing from FIQ routing. Directed sequences then cover the acknowledge and clear handshake: a second acknowledge during service, a multi-bit winner, and an IRQ clear aimed at an FIQ source. A final sequence makes a new edge collide with its own clear.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int SRC_N   = 26;
    localparam int BUS_DW  = 32;
    localparam int CTRL_W  = 3;
    localparam logic [CTRL_W-1:0] CTRL_RST = 3'b111;

    typedef enum logic [2:0] {
        RG_CTRL = 3'd0,
        RG_PEND = 3'd1,
        RG_ROUTE = 3'd2,
        RG_MASK = 3'd3,
        RG_INSV = 3'd4,
        RG_ICLR = 3'd5,
        RG_FCLR = 3'd6
    } reg_sel_e;
endpackage

// File: rtl/intr_edge_det.sv
module intr_edge_det #(
    parameter int N = intr_pkg::SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = src_i;
        rise_o = src_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/intr_cfg_regs.sv
module intr_cfg_regs #(
    parameter int N  = intr_pkg::SRC_N,
    parameter int CW = intr_pkg::CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [2:0]    addr_i,
    input  logic [N:0]    wdata_i,
    output logic [CW-1:0] ctrl_o,
    output logic [N-1:0]  route_o,
    output logic [N-1:0]  mask_o,
    output logic          gmask_o
);
    import intr_pkg::*;

    typedef struct packed {
        logic [CW-1:0] ctrl;
        logic [N-1:0]  route;
        logic [N:0]    mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (addr_i)
                RG_CTRL:  cfg_d.ctrl  = wdata_i[CW-1:0];
                RG_ROUTE: cfg_d.route = wdata_i[N-1:0];
                RG_MASK:  cfg_d.mask  = wdata_i;
                default:  ;
            endcase
        end
        ctrl_o  = cfg_q.ctrl;
        route_o = cfg_q.route;
        mask_o  = cfg_q.mask[N-1:0];
        gmask_o = cfg_q.mask[N];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.ctrl  <= CTRL_RST;
            cfg_q.route <= '0;
            cfg_q.mask  <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // R11: a mask write lands in the mask and global bits on the next cycle
    a_r11_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == RG_MASK) |=> ({gmask_o, mask_o} == $past(wdata_i)));
endmodule

// File: rtl/intr_pend_bank.sv
module intr_pend_bank #(
    parameter int N = intr_pkg::SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] irq_clr_i,
    input  logic [N-1:0] fiq_clr_i,
    input  logic [N-1:0] route_i,
    input  logic [N-1:0] cand_i,
    input  logic         ack_i,
    input  logic [N-1:0] winner_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] insv_o
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] insv;
    } svc_t;

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    svc_t         svc_d, svc_q;
    logic [N-1:0] drop;
    logic [N-1:0] pick;

    always_comb begin
        drop  = (irq_clr_i & ~route_i) | (fiq_clr_i & route_i);
        svc_d = svc_q;
        svc_d.pend = (svc_q.pend & ~drop) | rise_i;
        svc_d.insv = svc_q.insv & ~irq_clr_i;
        pick = winner_i & cand_i;
        if (ack_i && svc_q.insv == '0)
            svc_d.insv = pick & (~pick + ONE);
        pend_o = svc_q.pend;
        insv_o = svc_q.insv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_d;
    end

    // R7: in-service holds at most one bit
    a_r7_insv_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(insv_o));

    // R7: acknowledge during service leaves in-service untouched
    a_r7_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && insv_o != '0 && irq_clr_i == '0) |=> $stable(insv_o));

    // R2, R10: every rising edge shows up as pending, clear or not
    a_r10_rise_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((pend_o & $past(rise_i)) == $past(rise_i)));

    // R8: IRQ service clear empties the addressed in-service bits
    a_r8_insv_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i != '0) |=> ((insv_o & $past(irq_clr_i)) == '0));
endmodule

// File: rtl/intr_svc_unit.sv
module intr_svc_unit #(
    parameter int N  = intr_pkg::SRC_N,
    parameter int DW = intr_pkg::BUS_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_req_i,
    input  logic          bus_sel_i,
    input  logic          bus_wr_i,
    input  logic [2:0]    bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic [N-1:0]  irq_cand_o,
    input  logic [N-1:0]  arb_winner_i,
    input  logic          irq_ack_i,
    output logic          irq_req_o,
    output logic          fiq_req_o,
    output logic          vec_mode_o
);
    import intr_pkg::*;
    localparam int CW = CTRL_W;

    logic          wr_en;
    logic [N-1:0]  rise, pend, insv, route, mask;
    logic [N-1:0]  irq_clr, fiq_clr, fiq_pend;
    logic [CW-1:0] ctrl;
    logic          gmask;
    logic          unused_wdata;

    assign unused_wdata = ^bus_wdata_i[DW-1:N+1];

    always_comb begin
        wr_en   = bus_sel_i && bus_wr_i;
        irq_clr = (wr_en && bus_addr_i == RG_ICLR) ? bus_wdata_i[N-1:0] : '0;
        fiq_clr = (wr_en && bus_addr_i == RG_FCLR) ? bus_wdata_i[N-1:0] : '0;
    end

    intr_edge_det #(.N(N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_req_i),
        .rise_o (rise)
    );

    intr_cfg_regs #(.N(N), .CW(CW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i[N:0]),
        .ctrl_o  (ctrl),
        .route_o (route),
        .mask_o  (mask),
        .gmask_o (gmask)
    );

    intr_pend_bank #(.N(N)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .irq_clr_i (irq_clr),
        .fiq_clr_i (fiq_clr),
        .route_i   (route),
        .cand_i    (irq_cand_o),
        .ack_i     (irq_ack_i),
        .winner_i  (arb_winner_i),
        .pend_o    (pend),
        .insv_o    (insv)
    );

    always_comb begin
        irq_cand_o = gmask ? '0 : (pend & ~route & ~mask);
        fiq_pend   = gmask ? '0 : (pend & route & ~mask);
        irq_req_o  = !ctrl[1] && (irq_cand_o != '0) && (insv == '0);
        fiq_req_o  = !ctrl[0] && (fiq_pend != '0);
        vec_mode_o = !ctrl[2];
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            RG_CTRL:  bus_rdata_o = {{(DW-CW){1'b0}}, ctrl};
            RG_PEND:  bus_rdata_o = {{(DW-N){1'b0}}, pend};
            RG_ROUTE: bus_rdata_o = {{(DW-N){1'b0}}, route};
            RG_MASK:  bus_rdata_o = {{(DW-N-1){1'b0}}, gmask, mask};
            RG_INSV:  bus_rdata_o = {{(DW-N){1'b0}}, insv};
            default:  bus_rdata_o = '0;
        endcase
    end

    // R5: once an acknowledge loads in-service, the IRQ line drops next cycle
    a_r5_quiet_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && insv == '0 && (arb_winner_i & irq_cand_o) != '0)
        |=> !irq_req_o);
endmodule

// File: tb/tb_intr_svc_unit.sv
module tb_intr_svc_unit;
    localparam int N  = 26;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic          sel = 1'b0, wr = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [N-1:0]  cand;
    logic [N-1:0]  winner = '0;
    logic          ack = 1'b0;
    logic          irq, fiq, vec;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    intr_svc_unit #(.N(N), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .src_req_i(src),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_cand_o(cand), .arb_winner_i(winner), .irq_ack_i(ack),
        .irq_req_o(irq), .fiq_req_o(fiq), .vec_mode_o(vec)
    );

    typedef struct packed {
        logic [N-1:0] src;
        logic [N-1:0] route;
        logic [N:0]   mask;
    } vec_t;

    localparam vec_t VT [6] = '{
        '{src: 26'h3FFFFFF, route: 26'h0000000, mask: 27'h0000000},
        '{src: 26'h3FFFFFF, route: 26'h3FFFFFF, mask: 27'h0000000},
        '{src: 26'h3FFFFFF, route: 26'h0F0F0F0, mask: 27'h4000000},
        '{src: 26'h2000001, route: 26'h0000001, mask: 27'h0000000},
        '{src: 26'h0F0F0F0, route: 26'h0000000, mask: 27'h00F0000},
        '{src: 26'h2000000, route: 26'h0000000, mask: 27'h2000000}
    };

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [DW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [N-1:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
        src = '0;
    endtask

    task automatic clear_all();
        bus_wr(3'd5, 32'h03FFFFFF);
        bus_wr(3'd6, 32'h03FFFFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] r;
        logic [N-1:0]  ec, ef;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(3'd0, r); chk("R1 ctrl", r, 32'h7);
        bus_rd(3'd3, r); chk("R1 mask", r, 32'h07FFFFFF);
        bus_rd(3'd1, r); chk("R1 pend", r, 32'h0);
        bus_rd(3'd2, r); chk("R1 route", r, 32'h0);
        bus_rd(3'd4, r); chk("R1 insv", r, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 fiq", {31'b0, fiq}, 32'h0);

        bus_wr(3'd0, 32'h0);
        // R6 vectored select
        chk("R6 vec on", {31'b0, vec}, 32'h1);

        // R3 R4 R5 table walk
        foreach (VT[i]) begin
            bus_wr(3'd2, {6'b0, VT[i].route});
            bus_wr(3'd3, {5'b0, VT[i].mask});
            pulse(VT[i].src);
            ec = VT[i].mask[N] ? '0 : (VT[i].src & ~VT[i].route & ~VT[i].mask[N-1:0]);
            ef = VT[i].mask[N] ? '0 : (VT[i].src & VT[i].route & ~VT[i].mask[N-1:0]);
            chk("R3 cand", {6'b0, cand}, {6'b0, ec});
            chk("R5 irq", {31'b0, irq}, {31'b0, (ec != '0)});
            chk("R4 fiq", {31'b0, fiq}, {31'b0, (ef != '0)});
            clear_all();
            bus_rd(3'd1, r); chk("R9 R8 pend cleared", r, 32'h0);
        end

        bus_wr(3'd2, 32'h0);
        bus_wr(3'd3, 32'h0);

        // R2 sticky pending
        pulse(26'h8);
        @(negedge clk); @(negedge clk);
        bus_rd(3'd1, r); chk("R2 sticky", r, 32'h8);

        // R5 control disable
        bus_wr(3'd0, 32'h2);
        chk("R5 irq disabled", {31'b0, irq}, 32'h0);
        bus_wr(3'd0, 32'h0);
        chk("R5 irq enabled", {31'b0, irq}, 32'h1);
        clear_all();

        // R7 acknowledge and in-service
        pulse(26'h24);
        @(negedge clk); ack = 1'b1; winner = 26'h20;
        @(negedge clk); ack = 1'b0;
        bus_rd(3'd4, r); chk("R7 insv load", r, 32'h20);
        chk("R5 irq quiet in service", {31'b0, irq}, 32'h0);
        @(negedge clk); ack = 1'b1; winner = 26'h4;
        @(negedge clk); ack = 1'b0;
        bus_rd(3'd4, r); chk("R7 second ack ignored", r, 32'h20);
        bus_wr(3'd5, 32'h20);
        bus_rd(3'd4, r); chk("R8 insv cleared", r, 32'h0);
        bus_rd(3'd1, r); chk("R8 pend cleared", r, 32'h4);
        chk("R5 irq returns", {31'b0, irq}, 32'h1);
        clear_all();
        pulse(26'h24);
        @(negedge clk); ack = 1'b1; winner = 26'h24;
        @(negedge clk); ack = 1'b0;
        bus_rd(3'd4, r); chk("R7 lowest pick", r, 32'h4);
        bus_wr(3'd5, 32'h4);
        clear_all();

        // R9 FIQ clear only touches FIQ-routed sources
        bus_wr(3'd2, 32'h80);
        pulse(26'h80);
        chk("R4 fiq up", {31'b0, fiq}, 32'h1);
        bus_wr(3'd0, 32'h1);
        chk("R4 fiq disabled", {31'b0, fiq}, 32'h0);
        bus_wr(3'd0, 32'h0);
        bus_wr(3'd5, 32'h80);
        bus_rd(3'd1, r); chk("R8 irq clear spares fiq", r, 32'h80);
        bus_wr(3'd6, 32'h80);
        bus_rd(3'd1, r); chk("R9 fiq clear", r, 32'h0);
        chk("R9 fiq down", {31'b0, fiq}, 32'h0);
        bus_wr(3'd2, 32'h0);

        // R10 edge and clear collide
        pulse(26'h200);
        @(negedge clk);
        src = 26'h200; sel = 1'b1; wr = 1'b1; addr = 3'd5; wdata = 32'h200;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; src = '0;
        bus_rd(3'd1, r); chk("R10 rise beats clear", r, 32'h200);

        // R11 clear registers read zero
        bus_rd(3'd5, r); chk("R11 iclr reads 0", r, 32'h0);

        // R6 non-vectored
        bus_wr(3'd0, 32'h4);
        chk("R6 vec off", {31'b0, vec}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule